// File: doc/BRIEF.md
# Card and USB Port Status Interrupt Unit

This block watches seven slow, asynchronous level signals: one memory-card presence line and, for each of three USB ports, a PHY-ready line and a VBUS-present line. Each line is brought into the clock domain by a two-flop synchroniser. It is then followed by a small two-state tracker (`LINE_LOW`, `LINE_HIGH`). The tracker moves `LINE_LOW -> LINE_HIGH` on the transition named RISE and `LINE_HIGH -> LINE_LOW` on the transition named FALL. Each transition emits a one-cycle pulse in the cycle before it takes effect.

The pulses set sticky interrupt flags. Software reads the live levels and the flags through a 32-bit register bus and clears a flag by writing 1 to its bit. A single interrupt line is high while any flag is set. All trackers leave reset in `LINE_LOW`, so inputs are expected to be low while reset is applied.

Register offsets on the 8-bit byte address: `0x00` ready levels, `0x04` ready flags, `0x08` card level, `0x0C` card flags, `0x10` VBUS levels, `0x14` VBUS flags. Register reads are combinational. Writes take effect at the clock edge.

Top module: `port_status_irq`

## Requirements
- R1: After reset every register reads 0 and `irq_o` is low.
- R2: Bits 2:0 at offset 0x00 show the ready level of ports 2..0. A change on `usb_ready_i` appears there on the third rising clock edge after it.
- R3: A rising ready level sets the same bit at offset 0x04, on the same edge as R2. A falling ready level sets no flag.
- R4: Bit 0 at offset 0x08 shows the card presence level, with the timing of R2.
- R5: At offset 0x0C, bit 1 is set on a card insertion (rising presence) and bit 0 is set on a card removal (falling presence).
- R6: Bits 2:0 at offset 0x10 show the VBUS level of ports 2..0, with the timing of R2.
- R7: Either edge of a port's VBUS level sets that port's bit at offset 0x14.
- R8: Writing 1 to a flag bit clears it on that edge. Writing 0 leaves the bit unchanged. Writes to the level registers (0x00, 0x08, 0x10) change nothing.
- R9: When a new edge and a write-1 clear hit the same flag on the same edge, the flag stays set.
- R10: `irq_o` is high exactly while at least one flag bit is set.
- R11: Unused bits of every register read 0. Offsets other than the six listed read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe, sampled at the clock edge |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| card_present_i | input | 1 | Raw memory-card presence level |
| usb_ready_i | input | 3 | Raw PHY-ready level, one bit per port |
| usb_vbus_i | input | 3 | Raw VBUS-present level, one bit per port |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The assertions assume that each raw line holds a new level for at least three clock cycles before changing again, so that every level seen by a tracker is seen for at least one cycle. They also assume all lines are low while reset is applied, so that no edge is counted at release. The stimulus changes raw lines only on falling clock edges, keeps them low through reset and holds each level at least three cycles. The one case of a deliberate collision, a clear landing on the edge that sets the flag, is placed by counting the synchroniser and tracker edges.

// File: rtl/pstat_pkg.sv
package pstat_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFF_READY_LVL = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_READY_FLG = 8'h04;
    localparam logic [ADDR_W-1:0] OFF_CARD_LVL  = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_CARD_FLG  = 8'h0C;
    localparam logic [ADDR_W-1:0] OFF_VBUS_LVL  = 8'h10;
    localparam logic [ADDR_W-1:0] OFF_VBUS_FLG  = 8'h14;

    // card flag bit positions
    localparam int CARD_GONE_BIT = 0;
    localparam int CARD_IN_BIT   = 1;

    typedef enum logic {
        LINE_LOW  = 1'b0,
        LINE_HIGH = 1'b1
    } line_state_e;
endpackage

// File: rtl/pstat_sync.sv
module pstat_sync #(
    parameter int WIDTH  = 7,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[s] <= '0;
                    else        chain_q[s] <= raw_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[s] <= '0;
                    else        chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/pstat_edge_track.sv
module pstat_edge_track
    import pstat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);
    line_state_e state_q, state_d;

    // next-state process
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LINE_LOW:  if (level_i)  state_d = LINE_HIGH;  // RISE
            LINE_HIGH: if (!level_i) state_d = LINE_LOW;   // FALL
            default:   state_d = LINE_LOW;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LINE_LOW;
        else        state_q <= state_d;
    end

    // output process
    always_comb begin
        level_o = 1'b0;
        rise_o  = 1'b0;
        fall_o  = 1'b0;
        unique case (state_q)
            LINE_LOW: begin
                rise_o = level_i;
            end
            LINE_HIGH: begin
                level_o = 1'b1;
                fall_o  = !level_i;
            end
            default: ;
        endcase
    end

    p_rise_reaches_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> level_o);
    p_fall_reaches_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !level_o);
endmodule

// File: rtl/pstat_w1c.sv
module pstat_w1c #(
    parameter int WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] set_i,
    input  logic [WIDTH-1:0] clr_i,
    output logic [WIDTH-1:0] flag_o
);
    logic [WIDTH-1:0] flag_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= (flag_q & ~clr_i) | set_i;
    end

    assign flag_o = flag_q;

    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flag_o & $past(set_i)) == $past(set_i)));
    p_clear_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flag_o & $past(clr_i & ~set_i)) == '0));
    p_no_spurious_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flag_o & ~$past(flag_o) & ~$past(set_i)) == '0));
endmodule

// File: rtl/port_status_irq.sv
module port_status_irq
    import pstat_pkg::*;
#(
    parameter int NUM_PORTS   = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [7:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              card_present_i,
    input  logic [2:0]        usb_ready_i,
    input  logic [2:0]        usb_vbus_i,
    output logic              irq_o
);
    localparam int LINES    = 1 + 2 * NUM_PORTS;
    localparam int RDY_BASE = 1;
    localparam int VB_BASE  = 1 + NUM_PORTS;

    logic [LINES-1:0] raw, synced, lvl, rise, fall;

    assign raw = {usb_vbus_i[NUM_PORTS-1:0], usb_ready_i[NUM_PORTS-1:0], card_present_i};

    pstat_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .raw_i(raw), .sync_o(synced)
    );

    genvar l;
    generate
        for (l = 0; l < LINES; l++) begin : g_line
            pstat_edge_track u_track (
                .clk(clk), .rst_n(rst_n), .level_i(synced[l]),
                .level_o(lvl[l]), .rise_o(rise[l]), .fall_o(fall[l])
            );
        end
    endgenerate

    logic [NUM_PORTS-1:0] rdy_lvl, vb_lvl, rdy_set, vb_set, rdy_clr, vb_clr, rdy_flg, vb_flg;
    logic [1:0]           card_set, card_clr, card_flg;

    assign rdy_lvl = lvl[RDY_BASE +: NUM_PORTS];
    assign vb_lvl  = lvl[VB_BASE +: NUM_PORTS];

    always_comb begin
        rdy_set                = rise[RDY_BASE +: NUM_PORTS];
        vb_set                 = rise[VB_BASE +: NUM_PORTS] | fall[VB_BASE +: NUM_PORTS];
        card_set               = '0;
        card_set[CARD_IN_BIT]   = rise[0];
        card_set[CARD_GONE_BIT] = fall[0];
    end

    always_comb begin
        rdy_clr  = '0;
        vb_clr   = '0;
        card_clr = '0;
        if (bus_we) begin
            if (bus_addr == OFF_READY_FLG) rdy_clr  = bus_wdata[NUM_PORTS-1:0];
            if (bus_addr == OFF_VBUS_FLG)  vb_clr   = bus_wdata[NUM_PORTS-1:0];
            if (bus_addr == OFF_CARD_FLG)  card_clr = bus_wdata[1:0];
        end
    end

    logic wdata_unused;
    assign wdata_unused = ^bus_wdata[31:NUM_PORTS];

    pstat_w1c #(.WIDTH(NUM_PORTS)) u_rdy_flg (
        .clk(clk), .rst_n(rst_n), .set_i(rdy_set), .clr_i(rdy_clr), .flag_o(rdy_flg)
    );
    pstat_w1c #(.WIDTH(2)) u_card_flg (
        .clk(clk), .rst_n(rst_n), .set_i(card_set), .clr_i(card_clr), .flag_o(card_flg)
    );
    pstat_w1c #(.WIDTH(NUM_PORTS)) u_vb_flg (
        .clk(clk), .rst_n(rst_n), .set_i(vb_set), .clr_i(vb_clr), .flag_o(vb_flg)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFF_READY_LVL: bus_rdata[NUM_PORTS-1:0] = rdy_lvl;
            OFF_READY_FLG: bus_rdata[NUM_PORTS-1:0] = rdy_flg;
            OFF_CARD_LVL:  bus_rdata[0]             = lvl[0];
            OFF_CARD_FLG:  bus_rdata[1:0]           = card_flg;
            OFF_VBUS_LVL:  bus_rdata[NUM_PORTS-1:0] = vb_lvl;
            OFF_VBUS_FLG:  bus_rdata[NUM_PORTS-1:0] = vb_flg;
            default:       bus_rdata = '0;
        endcase
    end

    assign irq_o = |{rdy_flg, card_flg, vb_flg};

    p_edge_raises_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (|{rdy_set, card_set, vb_set}) |=> irq_o);
    p_ready_fall_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((fall[RDY_BASE +: NUM_PORTS] & ~rdy_flg) != '0) |=>
            ((rdy_flg & $past(fall[RDY_BASE +: NUM_PORTS] & ~rdy_flg)) == '0));
endmodule

// File: tb/test_port_status_irq.sv
module test_port_status_irq;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        card_present_i = 1'b0;
    logic [2:0]  usb_ready_i = 3'b000;
    logic [2:0]  usb_vbus_i = 3'b000;
    logic        irq_o;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    port_status_irq i_port_status_irq (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .card_present_i(card_present_i), .usb_ready_i(usb_ready_i),
        .usb_vbus_i(usb_vbus_i), .irq_o(irq_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = 32'h0;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        for (int a = 0; a <= 8'h14; a += 4) begin
            rd(a[7:0], d);
            check("R1 reset register", d, 32'h0);
        end
        check("R1 reset irq", {31'h0, irq_o}, 32'h0);
    endtask

    task automatic t_ready();
        logic [31:0] d;
        @(negedge clk); usb_ready_i = 3'b100;
        @(negedge clk); @(negedge clk);
        rd(8'h00, d); check("R2 ready level before third edge", d, 32'h0);
        @(negedge clk);
        rd(8'h00, d); check("R2 ready level", d, 32'h4);
        rd(8'h04, d); check("R3 ready rise flag", d, 32'h4);
        check("R10 irq with ready flag", {31'h0, irq_o}, 32'h1);
        wr(8'h04, 32'h0);
        rd(8'h04, d); check("R8 write 0 keeps flag", d, 32'h4);
        wr(8'h04, 32'h4);
        rd(8'h04, d); check("R8 write 1 clears flag", d, 32'h0);
        check("R10 irq low when flags clear", {31'h0, irq_o}, 32'h0);
        wr(8'h00, 32'hFFFF_FFFF);
        rd(8'h00, d); check("R8 level write ignored", d, 32'h4);
        @(negedge clk); usb_ready_i = 3'b000;
        settle();
        rd(8'h00, d); check("R2 ready level low", d, 32'h0);
        rd(8'h04, d); check("R3 ready fall no flag", d, 32'h0);
        check("R3 irq stays low", {31'h0, irq_o}, 32'h0);
    endtask

    task automatic t_card();
        logic [31:0] d;
        @(negedge clk); card_present_i = 1'b1;
        settle();
        rd(8'h08, d); check("R4 card level present", d, 32'h1);
        rd(8'h0C, d); check("R5 insertion bit1", d, 32'h2);
        wr(8'h0C, 32'h2);
        @(negedge clk); card_present_i = 1'b0;
        settle();
        rd(8'h08, d); check("R4 card level absent", d, 32'h0);
        rd(8'h0C, d); check("R5 removal bit0", d, 32'h1);
        check("R10 irq with card flag", {31'h0, irq_o}, 32'h1);
        wr(8'h0C, 32'hFFFF_FFFF);
        rd(8'h0C, d); check("R8 card flag cleared", d, 32'h0);
    endtask

    task automatic t_vbus();
        logic [31:0] d;
        @(negedge clk); usb_vbus_i = 3'b010;
        settle();
        rd(8'h10, d); check("R6 vbus level", d, 32'h2);
        rd(8'h14, d); check("R7 vbus rise flag", d, 32'h2);
        wr(8'h14, 32'h2);
        rd(8'h14, d); check("R8 vbus flag cleared", d, 32'h0);
        @(negedge clk); usb_vbus_i = 3'b001;
        settle();
        rd(8'h10, d); check("R6 vbus level moved", d, 32'h1);
        rd(8'h14, d); check("R7 vbus both edges", d, 32'h3);
        wr(8'h14, 32'h7);
        @(negedge clk); usb_vbus_i = 3'b000;
        settle();
        rd(8'h14, d); check("R7 vbus fall flag", d, 32'h1);
        wr(8'h14, 32'h1);
    endtask

    task automatic t_collision();
        logic [31:0] d;
        @(negedge clk); usb_ready_i = 3'b001;
        settle();
        @(negedge clk); usb_ready_i = 3'b000;
        settle();
        rd(8'h04, d); check("R9 setup flag", d, 32'h1);
        @(negedge clk); usb_ready_i = 3'b001;
        @(negedge clk);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 8'h04; bus_wdata = 32'h1;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = 32'h0;
        rd(8'h04, d); check("R9 edge wins over clear", d, 32'h1);
        wr(8'h04, 32'h1);
        rd(8'h04, d); check("R9 later clear works", d, 32'h0);
    endtask

    task automatic t_unused();
        logic [31:0] d;
        rd(8'h18, d); check("R11 unused offset", d, 32'h0);
        rd(8'h40, d); check("R11 far offset", d, 32'h0);
        rd(8'h02, d); check("R11 unaligned offset", d, 32'h0);
        rd(8'h00, d); check("R11 upper level bits zero", d & 32'hFFFF_FFF8, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ready();
        t_card();
        t_vbus();
        t_collision();
        t_unused();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule